// File: doc/BRIEF.md
# Serial memory status register and write guard

This unit keeps the 8-bit status register of a serial nonvolatile memory and decides, cycle by cycle, whether a byte write into the array or a write of the status register may go ahead. A command decoder upstream drives it with write-enable latch requests, the write-cycle busy flag, the active-low write-protect pin and the start of array or status write cycles. The unit returns the status byte for read-out and two permission flags that the decoder uses to start or drop a write cycle.

The two block-protect bits lock the top quarter, the top half or all of the array. The protect pin guards only the status register, and only when the pin-enable bit is set. The pin-enable and block-protect bits stand in for nonvolatile cells. A soft reset leaves them alone, and only the power-on reset clears them. The write-enable latch is volatile.

Top module: `ee_status_guard`

## Requirements
- R1: status_o is {wpen, 3'b000, bp[1], bp[0], wen, busy_i}. Bits 6..4 always read 0, and bit 0 follows busy_i in the same cycle.
- R2: After power-on reset (rst_ni low), wpen, bp and wen are all 0.
- R3: wen_set_i sets wen on the next clock and wen_clr_i clears it. wen_clr_i wins when both are high. While busy_i is 1, wen does not change.
- R4: arr_wr_ok_o is 1 only when wen=1, busy_i=0 and arr_addr_i is not protected.
- R5: Protection by bp. bp=00 protects nothing. bp=01 protects addresses whose two top bits are 11. bp=10 protects addresses whose top bit is 1. bp=11 protects every address.
- R6: sr_wr_ok_o is 1 only when wen=1, busy_i=0 and not (wpen=1 and wp_ni=0). A status write started with sr_wr_req_i while allowed loads wpen from data bit 7, bp[1] from bit 3 and bp[0] from bit 2. All other data bits are ignored.
- R7: wp_ni has no effect on arr_wr_ok_o.
- R8: With busy_i=0, any array or status write request clears wen on the next clock, whether the request is allowed or rejected. A rejected status write leaves wpen and bp unchanged.
- R9: soft_rst_i clears wen and keeps wpen and bp.
- R10: wp_ni is sampled only in the cycle of the status write request. Driving it low afterwards does not undo the new status value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset of volatile state |
| wen_set_i | input | 1 | Set write-enable latch |
| wen_clr_i | input | 1 | Clear write-enable latch |
| busy_i | input | 1 | Write cycle in progress |
| wp_ni | input | 1 | Write-protect pin, active low |
| sr_wr_req_i | input | 1 | Status write cycle start |
| sr_wr_data_i | input | 8 | Status write data |
| arr_wr_req_i | input | 1 | Array byte write cycle start |
| arr_addr_i | input | AW | Array byte address |
| status_o | output | 8 | Status byte |
| arr_wr_ok_o | output | 1 | Array write permitted at arr_addr_i |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
The assertions assume that the request inputs are single-cycle pulses driven by a decoder, and that write requests reach the unit only when its own permission flags are examined in the same cycle. They make no assumption about how the protect pin moves against the clock. The bench drives every input just after the falling edge and holds each request for exactly one cycle. It changes the protect pin only between requests, except in the one check that moves it right after a status write has committed.

// File: rtl/ee_sg_pkg.sv
package ee_sg_pkg;
  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_e;

  localparam int unsigned SR_WPEN = 7;
  localparam int unsigned SR_BP1  = 3;
  localparam int unsigned SR_BP0  = 2;
  localparam int unsigned SR_WEN  = 1;
  localparam int unsigned SR_BUSY = 0;
endpackage

// File: rtl/ee_sg_wel.sv
module ee_sg_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic busy_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_req_i,
  output logic wen_o
);
  logic wen_q;
  logic kill, arm;

  assign kill = soft_rst_i | (~busy_i & (clr_i | wr_req_i));
  assign arm  = ~busy_i & set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wen_q <= 1'b0;
    else if (kill) wen_q <= 1'b0;
    else if (arm)  wen_q <= 1'b1;
  end

  assign wen_o = wen_q;

  // R3: latch frozen while a write cycle runs
  a_r3_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !soft_rst_i |=> $stable(wen_o));
  // R8: every non-busy write request drops the latch
  a_r8_req_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && !busy_i |=> !wen_o);
  // R9
  a_r9_soft_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !wen_o);
endmodule

// File: rtl/ee_sg_nvbits.sv
module ee_sg_nvbits
  import ee_sg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       wpen_o,
  output bp_e        bp_o
);
  logic wpen_q;
  bp_e  bp_q;

  // power-on reset models the as-shipped contents; soft reset does not reach here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wpen_q <= 1'b0;
      bp_q   <= BP_NONE;
    end else if (load_i) begin
      wpen_q <= data_i[SR_WPEN];
      bp_q   <= bp_e'({data_i[SR_BP1], data_i[SR_BP0]});
    end
  end

  assign wpen_o = wpen_q;
  assign bp_o   = bp_q;

  // R8: no commit, no change
  a_r8_nv_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(wpen_o) && $stable(bp_o));
endmodule

// File: rtl/ee_sg_range.sv
module ee_sg_range
  import ee_sg_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  bp_e           bp_i,
  input  logic [AW-1:0] addr_i,
  output logic          locked_o
);
  localparam int unsigned TOP = AW - 1;

  logic [1:0] hi;

  generate
    if (AW >= 2) begin : g_wide
      assign hi = addr_i[TOP -: 2];
    end else begin : g_narrow
      assign hi = {addr_i[0], addr_i[0]};
    end
  endgenerate

  always_comb begin
    unique case (bp_i)
      BP_NONE:    locked_o = 1'b0;
      BP_QUARTER: locked_o = (hi == 2'b11);
      BP_HALF:    locked_o = hi[1];
      default:    locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ee_status_guard.sv
module ee_status_guard
  import ee_sg_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          wen_set_i,
  input  logic          wen_clr_i,
  input  logic          busy_i,
  input  logic          wp_ni,
  input  logic          sr_wr_req_i,
  input  logic [7:0]    sr_wr_data_i,
  input  logic          arr_wr_req_i,
  input  logic [AW-1:0] arr_addr_i,
  output logic [7:0]    status_o,
  output logic          arr_wr_ok_o,
  output logic          sr_wr_ok_o
);
  logic wen, wpen, locked, pin_block, sr_commit;
  bp_e  bp;

  ee_sg_wel u_wel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .busy_i     (busy_i),
    .set_i      (wen_set_i),
    .clr_i      (wen_clr_i),
    .wr_req_i   (sr_wr_req_i | arr_wr_req_i),
    .wen_o      (wen)
  );

  assign pin_block  = wpen & ~wp_ni;
  assign sr_wr_ok_o = wen & ~busy_i & ~pin_block;
  assign sr_commit  = sr_wr_req_i & sr_wr_ok_o;

  ee_sg_nvbits u_nv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sr_commit),
    .data_i (sr_wr_data_i),
    .wpen_o (wpen),
    .bp_o   (bp)
  );

  ee_sg_range #(.AW(AW)) u_range (
    .bp_i     (bp),
    .addr_i   (arr_addr_i),
    .locked_o (locked)
  );

  assign arr_wr_ok_o = wen & ~busy_i & ~locked;

  assign status_o = {wpen, 3'b000, bp[1], bp[0], wen, busy_i};

  // R1
  a_r1_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000);
  // R4
  a_r4_arr_needs_wen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_ok_o |-> status_o[SR_WEN] && !status_o[SR_BUSY]);
  // R5: whole-array lock
  a_r5_all_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[SR_BP1] && status_o[SR_BP0] |-> !arr_wr_ok_o);
  // R6
  a_r6_pin_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[SR_WPEN] && !wp_ni |-> !sr_wr_ok_o);
  // R6: status write loads only the three writable bits
  a_r6_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_req_i && sr_wr_ok_o |=>
      status_o[SR_WPEN] == $past(sr_wr_data_i[SR_WPEN]) &&
      status_o[SR_BP1]  == $past(sr_wr_data_i[SR_BP1]) &&
      status_o[SR_BP0]  == $past(sr_wr_data_i[SR_BP0]));
endmodule

// File: tb/ee_status_guard_tb.sv
module ee_status_guard_tb;
  localparam int unsigned AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic          wen_set = 1'b0, wen_clr = 1'b0, busy = 1'b0, wp_n = 1'b1;
  logic          sr_req = 1'b0, arr_req = 1'b0;
  logic [7:0]    sr_data = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0]    status;
  logic          arr_ok, sr_ok;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ee_status_guard #(.AW(AW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .soft_rst_i   (soft_rst),
    .wen_set_i    (wen_set),
    .wen_clr_i    (wen_clr),
    .busy_i       (busy),
    .wp_ni        (wp_n),
    .sr_wr_req_i  (sr_req),
    .sr_wr_data_i (sr_data),
    .arr_wr_req_i (arr_req),
    .arr_addr_i   (addr),
    .status_o     (status),
    .arr_wr_ok_o  (arr_ok),
    .sr_wr_ok_o   (sr_ok)
  );

  // {bp[1:0], addr[11:0], expected arr_ok with wen=1}
  localparam int unsigned NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {2'b00, 12'hFFF, 1'b1},
    {2'b00, 12'h000, 1'b1},
    {2'b01, 12'hBFF, 1'b1},
    {2'b01, 12'hC00, 1'b0},
    {2'b01, 12'hFFF, 1'b0},
    {2'b10, 12'h7FF, 1'b1},
    {2'b10, 12'h800, 1'b0},
    {2'b10, 12'hC00, 1'b0},
    {2'b11, 12'h000, 1'b0},
    {2'b11, 12'h7FF, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic set_wen();
    wen_set = 1'b1; cyc(); wen_set = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] d);
    sr_data = d; sr_req = 1'b1; cyc(); sr_req = 1'b0; sr_data = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check("R2 reset status", status, 8'h00);
    check("R2 reset arr_ok", {7'b0, arr_ok}, 8'h00);

    busy = 1'b1; #1;
    check("R1 busy bit", status, 8'h01);
    busy = 1'b0; #1;

    set_wen(); #1;
    check("R3 wen set", status, 8'h02);
    wen_set = 1'b1; wen_clr = 1'b1; cyc(); wen_set = 1'b0; wen_clr = 1'b0; #1;
    check("R3 clear wins", status, 8'h00);
    busy = 1'b1; set_wen(); busy = 1'b0; #1;
    check("R3 set ignored busy", status, 8'h00);

    // protection table
    for (int i = 0; i < NV; i++) begin
      set_wen();
      sr_write({4'b0000, VEC[i][14:13], 2'b00});
      set_wen();
      addr = VEC[i][12:1]; #1;
      check($sformatf("R5 R4 vec %0d", i), {7'b0, arr_ok}, {7'b0, VEC[i][0]});
    end

    // back to unprotected
    set_wen(); sr_write(8'h00); #1;
    check("R6 bp cleared", status, 8'h00);

    set_wen(); addr = 12'hFFF; busy = 1'b1; #1;
    check("R4 busy blocks arr", {7'b0, arr_ok}, 8'h00);
    busy = 1'b0; wp_n = 1'b0; #1;
    check("R7 wp ignored arr", {7'b0, arr_ok}, 8'h01);
    arr_req = 1'b1; cyc(); arr_req = 1'b0; wp_n = 1'b1; #1;
    check("R8 arr req clears wen", status, 8'h00);

    // loads only bits 7,3,2
    set_wen(); sr_write(8'hFF); #1;
    check("R6 write ff", status, 8'h8C);
    set_wen(); wp_n = 1'b0; #1;
    check("R6 pin blocks", {7'b0, sr_ok}, 8'h00);
    sr_write(8'h00); #1;
    check("R8 rejected keeps nv", status, 8'h8C);
    wp_n = 1'b1; set_wen(); #1;
    check("R6 pin high allows", {7'b0, sr_ok}, 8'h01);

    // WP after commit has no effect
    sr_data = 8'h84; sr_req = 1'b1; cyc(); sr_req = 1'b0; wp_n = 1'b0; cyc(); #1;
    check("R10 wp late", status, 8'h84);
    wp_n = 1'b1;

    set_wen(); sr_write(8'h08); set_wen(); #1;
    check("R9 before soft", status, 8'h0A);
    soft_rst = 1'b1; cyc(); soft_rst = 1'b0; #1;
    check("R9 soft keeps nv", status, 8'h08);

    do_reset(); #1;
    check("R2 power reset clears nv", status, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule